// File: doc/BRIEF.md
# Bus Access Violation Monitor

This block sits passively beside a processor-memory bus and judges every valid bus cycle against a small programmable memory map. Each region in the map has an inclusive lower and upper bound and a type: code, data, read-only, or unmapped. A separate permitted window limits the address space as a whole.

For each cycle the monitor uses the address, the transfer direction, whether the cycle is an instruction fetch, and an illegal-opcode indication from the decoder. From these it picks exactly one error class. The first violation sets a sticky error flag and stores the class and the offending address. Those values stay frozen until an explicit clear pulse. The monitor never drives the bus.

The map is written through a narrow configuration port. Reset loads a default map and a default permitted window.

Top module: `bus_guard`

## Requirements
- R1: After reset, `err_flag` is 0, `err_code` is 0 and `err_addr` is 0. Region i then covers i*REGION_SPAN to (i+1)*REGION_SPAN-1. Its type is i mod 4, with type encoding 0 code, 1 data, 2 read-only, 3 unmapped. The permitted window is PERMIT_LO to PERMIT_HI (defaults 0x0000 to 0x7FFF).
- R2: An instruction fetch (`bus_fetch`=1, direction ignored) to an address in a data region gives class 1.
- R3: A data read (`bus_fetch`=0, `bus_write`=0) to an address in a code region gives class 2.
- R4: A cycle to an address inside the permitted window that hits no region, or whose region is unmapped, gives class 3.
- R5: A data write to a read-only region gives class 4. Data writes to code or data regions and reads of read-only regions are legal.
- R6: A fetch from a code or read-only region with `bus_illop`=1 gives class 5. `bus_illop` has no effect on data cycles.
- R7: An address outside the permitted window gives class 6. Classes are ranked 6, then 3, then the type-based classes 1, 2 and 4, then 5.
- R8: The flag, class and address appear on the first rising edge that samples the offending `bus_valid`=1 cycle, and not before. Legal cycles and cycles with `bus_valid`=0 change nothing.
- R9: Once the flag is set, later violations leave the flag, class and address unchanged.
- R10: `err_clear`=1 at a rising edge returns the flag, class and address to 0. A violation sampled at that same edge is dropped.
- R11: `cfg_we`=1 with `cfg_idx`<NUM_REGIONS loads that region's bounds and type. With `cfg_idx`=NUM_REGIONS it loads the permitted window from `cfg_base`/`cfg_limit`. The new map judges cycles sampled after that edge. Where regions overlap, the lowest-numbered region decides the type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_illop | input | 1 | Decoder reports an illegal opcode |
| bus_addr | input | ADDR_W | Bus address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Region number, or NUM_REGIONS for the permitted window |
| cfg_base | input | ADDR_W | Lower bound (inclusive) |
| cfg_limit | input | ADDR_W | Upper bound (inclusive) |
| cfg_kind | input | 2 | Region type: 0 code, 1 data, 2 read-only, 3 unmapped |
| err_clear | input | 1 | Clears the captured violation |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Captured class, 0 when none |
| err_addr | output | ADDR_W | Captured offending address |

## Verification
Each class is computed combinationally from the registered map. The result is then stored by a single register stage, so all three outputs are due exactly one rising edge after the sampled bus cycle. The bench drives every cycle on a falling edge and drops `bus_valid` at the next falling edge. It then reads the outputs at that falling edge, half a period after the capturing edge. One test also reads the flag just before that edge, to confirm it is still low. Configuration writes and clear pulses use the same falling-edge pattern, so each write or clear has taken effect before the next bus cycle is sampled.

// File: rtl/bus_guard_pkg.sv
// Shared types for the bus access violation monitor.
package bus_guard_pkg;

    // Region type held in each map entry
    typedef enum logic [1:0] {
        RK_CODE     = 2'd0,
        RK_DATA     = 2'd1,
        RK_RDONLY   = 2'd2,
        RK_UNMAPPED = 2'd3
    } region_kind_e;

    // Violation class; the numeric values are visible at the top-level port
    typedef enum logic [2:0] {
        EC_NONE        = 3'd0,
        EC_FETCH_DATA  = 3'd1,
        EC_READ_CODE   = 3'd2,
        EC_NO_MEMORY   = 3'd3,
        EC_RDONLY_WR   = 3'd4,
        EC_BAD_OPCODE  = 3'd5,
        EC_OUT_OF_WIN  = 3'd6
    } err_class_e;

endpackage

// File: rtl/bus_guard_map.sv
// Programmable memory map: region bound/type registers and the permitted window.
// Performs the address lookup combinationally against the registered map.
// Assumes: bounds are inclusive; the lowest-numbered matching region wins.
module bus_guard_map
    import bus_guard_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NUM_REGIONS = 4,
    parameter int REGION_SPAN = 4096,
    parameter int PERMIT_LO   = 0,
    parameter int PERMIT_HI   = 32767,
    parameter int IDX_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [1:0]        cfg_kind,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit_any,
    output region_kind_e      hit_kind,
    output logic              in_window
);

    logic [NUM_REGIONS-1:0]      hit_v;
    logic [NUM_REGIONS-1:0][1:0] kind_v;
    logic [ADDR_W-1:0]           win_lo_q;
    logic [ADDR_W-1:0]           win_hi_q;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam logic [ADDR_W-1:0] RST_BASE  = ADDR_W'(g * REGION_SPAN);
        localparam logic [ADDR_W-1:0] RST_LIMIT = ADDR_W'((g + 1) * REGION_SPAN - 1);
        localparam logic [1:0]        RST_KIND  = 2'(g % 4);

        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] limit_q;
        logic [1:0]        kind_q;

        // Load this region's entry at reset or from the config port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= RST_BASE;
                limit_q <= RST_LIMIT;
                kind_q  <= RST_KIND;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                base_q  <= cfg_base;
                limit_q <= cfg_limit;
                kind_q  <= cfg_kind;
            end
        end

        assign hit_v[g]  = (look_addr >= base_q) && (look_addr <= limit_q);
        assign kind_v[g] = kind_q;

        // R11: a config write to this index is visible on the next cycle
        p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == IDX_W'(g)) |=>
                (base_q == $past(cfg_base) && limit_q == $past(cfg_limit)
                 && kind_q == $past(cfg_kind)));
    end

    // Load the permitted window at reset or from the config port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_lo_q <= ADDR_W'(PERMIT_LO);
            win_hi_q <= ADDR_W'(PERMIT_HI);
        end else if (cfg_we && cfg_idx == IDX_W'(NUM_REGIONS)) begin
            win_lo_q <= cfg_base;
            win_hi_q <= cfg_limit;
        end
    end

    // Pick the type of the lowest-numbered matching region
    always_comb begin
        hit_any  = |hit_v;
        hit_kind = RK_UNMAPPED;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_v[i]) hit_kind = region_kind_e'(kind_v[i]);
        end
    end

    assign in_window = (look_addr >= win_lo_q) && (look_addr <= win_hi_q);

endmodule

// File: rtl/bus_guard_classify.sv
// Sorts one bus cycle into a single violation class from its kind and the map lookup.
// Assumes: purely combinational; the ranking is window, then existence, then
// type-based checks, then the illegal-opcode indication.
module bus_guard_classify
    import bus_guard_pkg::*;
(
    input  logic         valid,
    input  logic         write,
    input  logic         fetch,
    input  logic         illop,
    input  logic         in_window,
    input  logic         hit_any,
    input  region_kind_e hit_kind,
    output err_class_e   cls
);

    // Apply the ranked checks in order
    always_comb begin
        cls = EC_NONE;
        if (valid) begin
            if (!in_window) begin
                cls = EC_OUT_OF_WIN;
            end else if (!hit_any || hit_kind == RK_UNMAPPED) begin
                cls = EC_NO_MEMORY;
            end else if (fetch) begin
                if (hit_kind == RK_DATA)  cls = EC_FETCH_DATA;
                else if (illop)           cls = EC_BAD_OPCODE;
            end else if (write) begin
                if (hit_kind == RK_RDONLY) cls = EC_RDONLY_WR;
            end else if (hit_kind == RK_CODE) begin
                cls = EC_READ_CODE;
            end
        end
    end

endmodule

// File: rtl/bus_guard_capture.sv
// Sticky capture of the first violation: flag, class and address.
// Assumes: clear outranks a violation arriving at the same edge.
module bus_guard_capture
    import bus_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr_in,
    input  err_class_e        cls_in,
    output logic              flag_q,
    output err_class_e        cls_q,
    output logic [ADDR_W-1:0] addr_q
);

    // Hold the first violation until cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flag_q <= 1'b0;
            cls_q  <= EC_NONE;
            addr_q <= '0;
        end else if (!flag_q && cls_in != EC_NONE) begin
            flag_q <= 1'b1;
            cls_q  <= cls_in;
            addr_q <= addr_in;
        end
    end

    // R8: a fresh violation is captured on the next edge
    p_first_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !clear && cls_in != EC_NONE) |=>
            (flag_q && cls_q == $past(cls_in) && addr_q == $past(addr_in)));

    // R9: a set flag freezes the record while no clear is given
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear) |=> (flag_q && $stable(cls_q) && $stable(addr_q)));

    // R10: clear empties the record on the next edge
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!flag_q && cls_q == EC_NONE));

endmodule

// File: rtl/bus_guard.sv
// Bus access violation monitor top: map lookup, classification and sticky capture.
// Assumes: passive observer; bus inputs are synchronous to clk.
module bus_guard
    import bus_guard_pkg::*;
#(
    parameter  int ADDR_W      = 16,
    parameter  int NUM_REGIONS = 4,
    parameter  int REGION_SPAN = 4096,
    parameter  int PERMIT_LO   = 0,
    parameter  int PERMIT_HI   = 32767,
    localparam int IDX_W       = $clog2(NUM_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_fetch,
    input  logic              bus_illop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [1:0]        cfg_kind,
    input  logic              err_clear,
    output logic              err_flag,
    output logic [2:0]        err_code,
    output logic [ADDR_W-1:0] err_addr
);

    logic         hit_any;
    region_kind_e hit_kind;
    logic         in_window;
    err_class_e   cycle_cls;
    err_class_e   held_cls;

    bus_guard_map #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .REGION_SPAN(REGION_SPAN),
        .PERMIT_LO(PERMIT_LO), .PERMIT_HI(PERMIT_HI), .IDX_W(IDX_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_kind(cfg_kind),
        .look_addr(bus_addr),
        .hit_any(hit_any), .hit_kind(hit_kind), .in_window(in_window)
    );

    bus_guard_classify u_cls (
        .valid(bus_valid), .write(bus_write), .fetch(bus_fetch), .illop(bus_illop),
        .in_window(in_window), .hit_any(hit_any), .hit_kind(hit_kind),
        .cls(cycle_cls)
    );

    bus_guard_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(err_clear),
        .addr_in(bus_addr), .cls_in(cycle_cls),
        .flag_q(err_flag), .cls_q(held_cls), .addr_q(err_addr)
    );

    assign err_code = held_cls;

    // R8: with no bus cycle and no pending record, the flag stays low
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !err_flag) |=> !err_flag);

    // R1: the flag and the class agree at every edge after reset
    p_flag_matches_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_code != 3'd0));

endmodule

// File: tb/bus_guard_tb_top.sv
`timescale 1ns/1ps
module bus_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_fetch = 1'b0, bus_illop = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0, cfg_limit = '0;
    logic [1:0]  cfg_kind = '0;
    logic        err_clear = 1'b0;
    logic        err_flag;
    logic [2:0]  err_code;
    logic [15:0] err_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bus_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_fetch(bus_fetch),
        .bus_illop(bus_illop), .bus_addr(bus_addr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_kind(cfg_kind),
        .err_clear(err_clear),
        .err_flag(err_flag), .err_code(err_code), .err_addr(err_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_err(input string req, input logic [2:0] code, input logic [15:0] a);
        chk(req, "flag", 32'(err_flag), 32'd1);
        chk(req, "code", 32'(err_code), 32'(code));
        chk(req, "addr", 32'(err_addr), 32'(a));
    endtask

    task automatic expect_quiet(input string req);
        chk(req, "flag", 32'(err_flag), 32'd0);
        chk(req, "code", 32'(err_code), 32'd0);
    endtask

    // One valid bus cycle; returns at the falling edge after the sampling edge
    task automatic bus_cycle(input logic [15:0] a, input logic w, input logic f, input logic il);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = w; bus_fetch = f; bus_illop = il;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_fetch = 1'b0; bus_illop = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [15:0] lo,
                             input logic [15:0] hi, input logic [1:0] kind);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = lo; cfg_limit = hi; cfg_kind = kind;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        expect_quiet("R1");
        chk("R1", "addr", 32'(err_addr), 32'd0);
    endtask

    task automatic t_legal();
        bus_cycle(16'h0100, 1'b0, 1'b1, 1'b0); expect_quiet("R8 fetch code");
        bus_cycle(16'h2100, 1'b0, 1'b1, 1'b0); expect_quiet("R8 fetch rdonly");
        bus_cycle(16'h1100, 1'b0, 1'b0, 1'b0); expect_quiet("R8 read data");
        bus_cycle(16'h2200, 1'b0, 1'b0, 1'b0); expect_quiet("R5 read rdonly");
        bus_cycle(16'h1200, 1'b1, 1'b0, 1'b0); expect_quiet("R5 write data");
        bus_cycle(16'h0200, 1'b1, 1'b0, 1'b0); expect_quiet("R5 write code");
        // bad address with bus_valid low
        @(negedge clk); bus_addr = 16'h9000; bus_write = 1'b1;
        @(negedge clk); bus_write = 1'b0;
        expect_quiet("R8 valid low");
    endtask

    task automatic t_fetch_data();
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 16'h1234; bus_fetch = 1'b1;
        #1;
        chk("R8", "flag before edge", 32'(err_flag), 32'd0);
        @(negedge clk);
        bus_valid = 1'b0; bus_fetch = 1'b0;
        expect_err("R2", 3'd1, 16'h1234);
        pulse_clear();
        expect_quiet("R10 after clear");
    endtask

    task automatic t_read_code();
        bus_cycle(16'h0456, 1'b0, 1'b0, 1'b0); expect_err("R3", 3'd2, 16'h0456);
        pulse_clear();
    endtask

    task automatic t_no_memory();
        bus_cycle(16'h3010, 1'b0, 1'b0, 1'b0); expect_err("R4 unmapped", 3'd3, 16'h3010);
        pulse_clear();
        bus_cycle(16'h5000, 1'b1, 1'b0, 1'b0); expect_err("R4 no region", 3'd3, 16'h5000);
        pulse_clear();
    endtask

    task automatic t_rdonly_write();
        bus_cycle(16'h2ABC, 1'b1, 1'b0, 1'b0); expect_err("R5", 3'd4, 16'h2ABC);
        pulse_clear();
    endtask

    task automatic t_illop();
        bus_cycle(16'h0010, 1'b0, 1'b1, 1'b1); expect_err("R6 fetch", 3'd5, 16'h0010);
        pulse_clear();
        bus_cycle(16'h1010, 1'b0, 1'b0, 1'b1); expect_quiet("R6 data cycle");
        bus_cycle(16'h1010, 1'b0, 1'b1, 1'b1); expect_err("R7 rank 1 over 5", 3'd1, 16'h1010);
        pulse_clear();
    endtask

    task automatic t_window();
        bus_cycle(16'h9000, 1'b0, 1'b0, 1'b0); expect_err("R7", 3'd6, 16'h9000);
        pulse_clear();
        bus_cycle(16'hF000, 1'b1, 1'b1, 1'b1); expect_err("R7 rank 6 first", 3'd6, 16'hF000);
        pulse_clear();
    endtask

    task automatic t_sticky();
        bus_cycle(16'h0456, 1'b0, 1'b0, 1'b0);
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b0);
        expect_err("R9", 3'd2, 16'h0456);
        bus_cycle(16'h9999, 1'b0, 1'b0, 1'b0);
        expect_err("R9 second", 3'd2, 16'h0456);
        pulse_clear();
        expect_quiet("R10");
    endtask

    task automatic t_clear_wins();
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 16'h9000; err_clear = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; err_clear = 1'b0;
        expect_quiet("R10 same edge");
        bus_cycle(16'h2ABC, 1'b1, 1'b0, 1'b0); expect_err("R10 recapture", 3'd4, 16'h2ABC);
        pulse_clear();
    endtask

    task automatic t_config();
        cfg_write(3'd3, 16'h3000, 16'h3FFF, 2'd1);
        bus_cycle(16'h3100, 1'b0, 1'b1, 1'b0); expect_err("R11 region", 3'd1, 16'h3100);
        pulse_clear();
        cfg_write(3'd4, 16'h0000, 16'hFFFF, 2'd0);
        bus_cycle(16'h9000, 1'b0, 1'b0, 1'b0); expect_err("R11 window", 3'd3, 16'h9000);
        pulse_clear();
        cfg_write(3'd1, 16'h0000, 16'h1FFF, 2'd1);
        bus_cycle(16'h0100, 1'b0, 1'b0, 1'b0); expect_err("R11 overlap", 3'd2, 16'h0100);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_legal();
        t_fetch_data();
        t_read_code();
        t_no_memory();
        t_rdonly_write();
        t_illop();
        t_window();
        t_sticky();
        t_clear_wins();
        t_config();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule